// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Two-Entry Holding FIFO

This block turns a single asynchronous serial line into received words for a host. A programmable divisor sets an oversampling tick sixteen times the bit rate; a falling edge on the idle line starts a frame. The start bit is confirmed at its centre, and each data bit and the stop bit are decided by a 2-of-3 vote of samples taken around the bit centre. Frames carry 8 or 9 data bits, least significant bit first.

Each finished word is pushed, together with its ninth bit and a framing-error flag, into a two-entry FIFO. The host sees the head entry on a read port and pops it with a one-cycle strobe. A ready flag shows that the FIFO holds data, and an interrupt line copies it when enabled. If a word completes while both entries are held, a sticky overrun flag is raised and the word is lost. Later words are also dropped until reception is switched off, which returns the receiver to idle and clears the overrun. The stored words are kept through that.

Top module: `serial_rx_core`

## Requirements
- R1: With divisor D, one bit lasts 16*(D+1) clock cycles; frames sent at that rate are received with data bit 0 first, and an 8-bit word appears on `rd_data`.
- R2: Reception runs only while `cfg_port_en`=1, `cfg_cont_rx`=1 and `cfg_sync_mode`=0; in any other setting a frame on the line leaves `rx_ready` at 0.
- R3: `cfg_nine_bit`=1 selects 9 data bits; the last data bit received appears on `rd_bit9`, and `rd_data` holds the first eight. In 8-bit mode `rd_bit9` is 0.
- R4: A word whose stop bit votes low carries `rd_frame_err`=1; a word with a high stop bit carries 0.
- R5: `rx_ready` is 1 exactly while the FIFO holds at least one word and drops when the last one is popped; `rx_irq` equals `rx_ready` while `cfg_irq_en`=1 and is 0 otherwise.
- R6: The FIFO holds two words and returns them in arrival order; each cycle with `rd_pop`=1 removes the head word; a pop while empty changes nothing.
- R7: A word completing while two words are held (and no pop in that cycle) sets `rd_overrun` and is discarded; while `rd_overrun` is 1 every completed word is discarded.
- R8: Dropping `cfg_cont_rx` or `cfg_port_en` clears `rd_overrun` at the next clock and returns the receiver to idle; FIFO contents are kept and the next frame after re-enable is received correctly.
- R9: The start bit is confirmed by a 2-of-3 vote at oversample phases 7, 8 and 9; a low pulse shorter than that window is a false start and produces no word.
- R10: Each data and stop bit is the 2-of-3 vote of samples at oversample phases 7, 8 and 9; a glitch one oversample tick wide at the bit centre does not change the received value.
- R11: If a word completes in the same cycle as a pop with the FIFO full, the pop is served first, the word is stored, and `rd_overrun` stays 0.
- R12: After reset `rx_ready`, `rx_irq` and `rd_overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_divisor | input | DIV_W | Baud divisor D; oversample tick every D+1 clocks |
| cfg_port_en | input | 1 | Serial port enable |
| cfg_cont_rx | input | 1 | Continuous receive enable |
| cfg_sync_mode | input | 1 | 1 selects synchronous mode, which halts this receiver |
| cfg_nine_bit | input | 1 | 1 selects 9 data bits per frame |
| cfg_irq_en | input | 1 | Receive interrupt enable |
| rx_line | input | 1 | Serial input, idle high |
| rd_pop | input | 1 | Pop the head word (one per cycle) |
| rd_data | output | 8 | Head word data |
| rd_bit9 | output | 1 | Head word ninth bit |
| rd_frame_err | output | 1 | Head word framing error |
| rd_overrun | output | 1 | Sticky overrun flag |
| rx_ready | output | 1 | FIFO not empty |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The two functions that can coincide are the completion of a word into a full FIFO and a host pop of the head entry. The bench first measures the latency from a frame's start edge to the push on an empty FIFO right after re-enabling, which restarts the tick counter. It then fills the FIFO, re-enables again and sends a third frame while pulsing the pop strobe on exactly the measured push edge. The outcome is judged at the ports: overrun must stay clear and the reads must return the second and third words in order. A separate run without the pop must set overrun and drop the third word.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_t;

  typedef struct packed {
    logic [7:0] data;
    logic       bit9;
    logic       ferr;
  } rx_word_t;

  // 2-of-3 vote
  function automatic logic maj3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

  // Align the shift register contents for 8- or 9-bit frames
  function automatic rx_word_t pack_word(input logic [8:0] sh,
                                         input logic       nine,
                                         input logic       stop_lvl);
    rx_word_t w;
    w.data = nine ? sh[7:0] : sh[8:1];
    w.bit9 = nine & sh[8];
    w.ferr = ~stop_lvl;
    return w;
  endfunction

endpackage

// File: rtl/srx_baud_tick.sv
module srx_baud_tick #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = en && (cnt == divisor);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!en || tick) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (divisor != '0)) |=> (!tick || (divisor == '0))); // R1

endmodule

// File: rtl/srx_deframer.sv
module srx_deframer import srx_pkg::*; #(
  parameter int OVS = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     tick,
  input  logic     rx,
  input  logic     nine_bit,
  output logic     word_done,
  output rx_word_t word_q
);

  // OVS is a power of two so the phase counter wraps by itself
  localparam int PH_W = $clog2(OVS);
  localparam logic [PH_W-1:0] S_LO = PH_W'(OVS/2 - 1);
  localparam logic [PH_W-1:0] S_HI = PH_W'(OVS/2 + 1);
  localparam logic [PH_W-1:0] LAST = PH_W'(OVS - 1);

  rx_state_t       state;
  logic [PH_W-1:0] phase;
  logic [3:0]      bitcnt;
  logic [2:0]      samp;
  logic [8:0]      sh;
  logic            nine_q;
  logic [3:0]      last_bit;
  logic            vote_now;

  assign last_bit = nine_q ? 4'd8 : 4'd7;
  assign vote_now = maj3({samp[1:0], rx});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      phase     <= '0;
      bitcnt    <= '0;
      samp      <= '0;
      sh        <= '0;
      nine_q    <= 1'b0;
      word_done <= 1'b0;
      word_q    <= '0;
    end else begin
      word_done <= 1'b0;
      if (!en) begin
        state  <= ST_IDLE;
        phase  <= '0;
        bitcnt <= '0;
      end else if (tick) begin
        if (phase >= S_LO && phase <= S_HI) samp <= {samp[1:0], rx};
        phase <= phase + 1'b1;
        case (state)
          ST_IDLE: begin
            phase <= '0;
            if (!rx) begin
              state  <= ST_START;
              phase  <= PH_W'(1);
              nine_q <= nine_bit;
            end
          end
          ST_START: begin
            if (phase == S_HI && vote_now) state <= ST_IDLE;
            else if (phase == LAST) begin
              state  <= ST_DATA;
              bitcnt <= '0;
            end
          end
          ST_DATA: begin
            if (phase == LAST) begin
              sh     <= {maj3(samp), sh[8:1]};
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == last_bit) state <= ST_STOP;
            end
          end
          ST_STOP: begin
            if (phase == S_HI) begin
              word_done <= 1'b1;
              word_q    <= pack_word(sh, nine_q, vote_now);
              state     <= ST_IDLE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_DONE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> $past(en)); // R2
  AST_BITS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA) |-> (bitcnt <= 4'd8)); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> !word_done); // R4

endmodule

// File: rtl/srx_fifo.sv
module srx_fifo import srx_pkg::*; #(
  parameter int DEPTH = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  logic     pop,
  input  rx_word_t wdata,
  output rx_word_t rdata,
  output logic     empty,
  output logic     full
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  rx_word_t         mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             do_pop, do_push;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign rdata   = mem[rd_ptr];

  function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= next_ptr(wr_ptr);
      if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R6
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !pop) |=> (count == $past(count) + 1'b1)); // R6
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty); // R6

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core import srx_pkg::*; #(
  parameter int DIV_W = 12,
  parameter int OVS   = 16,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_divisor,
  input  logic             cfg_port_en,
  input  logic             cfg_cont_rx,
  input  logic             cfg_sync_mode,
  input  logic             cfg_nine_bit,
  input  logic             cfg_irq_en,
  input  logic             rx_line,
  input  logic             rd_pop,
  output logic [7:0]       rd_data,
  output logic             rd_bit9,
  output logic             rd_frame_err,
  output logic             rd_overrun,
  output logic             rx_ready,
  output logic             rx_irq
);

  logic     rx_meta, rx_sync;
  logic     rx_en, tick;
  logic     word_done;
  rx_word_t word_q, head;
  logic     fifo_empty, fifo_full;
  logic     accept, ovr_set, ovr;

  assign rx_en = cfg_port_en && cfg_cont_rx && !cfg_sync_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_meta <= 1'b1;
      rx_sync <= 1'b1;
    end else begin
      rx_meta <= rx_line;
      rx_sync <= rx_meta;
    end
  end

  srx_baud_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .divisor(cfg_divisor), .tick(tick)
  );

  srx_deframer #(.OVS(OVS)) u_deframer (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(tick), .rx(rx_sync),
    .nine_bit(cfg_nine_bit), .word_done(word_done), .word_q(word_q)
  );

  // A pop in the completion cycle frees a slot before the push
  assign accept  = word_done && !ovr && (!fifo_full || (rd_pop && !fifo_empty));
  assign ovr_set = word_done && !ovr && fifo_full && !rd_pop;

  srx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(accept), .pop(rd_pop), .wdata(word_q),
    .rdata(head), .empty(fifo_empty), .full(fifo_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovr <= 1'b0;
    else if (!rx_en)  ovr <= 1'b0;
    else if (ovr_set) ovr <= 1'b1;
  end

  assign rd_data      = head.data;
  assign rd_bit9      = head.bit9;
  assign rd_frame_err = head.ferr;
  assign rd_overrun   = ovr;
  assign rx_ready     = !fifo_empty;
  assign rx_irq       = rx_ready && cfg_irq_en;

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_overrun && rx_en) |=> rd_overrun); // R7
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_overrun) |-> $past(word_done && fifo_full)); // R7
  AST_OVR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rd_overrun); // R8
  AST_SAME_CYCLE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && fifo_full && rd_pop && !rd_overrun && rx_en) |=> (!rd_overrun && fifo_full)); // R11

endmodule

// File: tb/test_serial_rx_core.sv
`timescale 1ns/1ps
module test_serial_rx_core;

  localparam int DIV    = 3;
  localparam int TICK   = DIV + 1;
  localparam int BITCLK = 16 * TICK;
  localparam int NOG    = 99;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [11:0] cfg_divisor = 12'(DIV);
  logic       cfg_port_en = 1'b1, cfg_cont_rx = 1'b1, cfg_sync_mode = 1'b0;
  logic       cfg_nine_bit = 1'b0, cfg_irq_en = 1'b0;
  logic       rx_line = 1'b1, rd_pop = 1'b0;
  logic [7:0] rd_data;
  logic       rd_bit9, rd_frame_err, rd_overrun, rx_ready, rx_irq;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int t0, lat;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serial_rx_core i_serial_rx_core (
    .clk(clk), .rst_n(rst_n), .cfg_divisor(cfg_divisor), .cfg_port_en(cfg_port_en),
    .cfg_cont_rx(cfg_cont_rx), .cfg_sync_mode(cfg_sync_mode), .cfg_nine_bit(cfg_nine_bit),
    .cfg_irq_en(cfg_irq_en), .rx_line(rx_line), .rd_pop(rd_pop), .rd_data(rd_data),
    .rd_bit9(rd_bit9), .rd_frame_err(rd_frame_err), .rd_overrun(rd_overrun),
    .rx_ready(rx_ready), .rx_irq(rx_irq)
  );

  typedef struct packed {
    logic [8:0] val;
    logic       nine;
    logic       stop;
    logic [7:0] exp_d;
    logic       exp_b9;
    logic       exp_fe;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{val:9'h0A5, nine:1'b0, stop:1'b1, exp_d:8'hA5, exp_b9:1'b0, exp_fe:1'b0},
    '{val:9'h03C, nine:1'b0, stop:1'b1, exp_d:8'h3C, exp_b9:1'b0, exp_fe:1'b0},
    '{val:9'h1FF, nine:1'b1, stop:1'b1, exp_d:8'hFF, exp_b9:1'b1, exp_fe:1'b0},
    '{val:9'h100, nine:1'b1, stop:1'b1, exp_d:8'h00, exp_b9:1'b1, exp_fe:1'b0},
    '{val:9'h055, nine:1'b0, stop:1'b0, exp_d:8'h55, exp_b9:1'b0, exp_fe:1'b1},
    '{val:9'h081, nine:1'b1, stop:1'b0, exp_d:8'h81, exp_b9:1'b0, exp_fe:1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at a negedge
  task automatic send_frame(input logic [8:0] val, input logic nine, input logic stop, input int gl);
    rx_line = 1'b0;
    repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      rx_line = val[i];
      if (i == gl) begin
        repeat (32) @(negedge clk);
        rx_line = ~val[i];
        repeat (TICK) @(negedge clk);
        rx_line = val[i];
        repeat (BITCLK - 32 - TICK) @(negedge clk);
      end else begin
        repeat (BITCLK) @(negedge clk);
      end
    end
    rx_line = stop;
    repeat (BITCLK) @(negedge clk);
    rx_line = 1'b1;
    repeat (2 * BITCLK) @(negedge clk);
  endtask

  task automatic pop_one();
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  task automatic reenable();
    @(negedge clk) cfg_cont_rx = 1'b0;
    @(negedge clk) cfg_cont_rx = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 ready in reset", rx_ready, 0);
    chk("R12 overrun in reset", rd_overrun, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 ready after reset", rx_ready, 0);
    chk("R12 irq after reset", rx_irq, 0);
    chk("R12 overrun after reset", rd_overrun, 0);

    // Vector table: R1 R3 R4
    for (int v = 0; v < 6; v++) begin
      cfg_nine_bit = VEC[v].nine;
      send_frame(VEC[v].val, VEC[v].nine, VEC[v].stop, NOG);
      chk("R5 ready after frame", rx_ready, 1);
      chk("R1 data", rd_data, VEC[v].exp_d);
      chk("R3 ninth bit", rd_bit9, VEC[v].exp_b9);
      chk("R4 framing error", rd_frame_err, VEC[v].exp_fe);
      pop_one();
      chk("R5 ready after last pop", rx_ready, 0);
    end
    cfg_nine_bit = 1'b0;

    // Interrupt gating R5
    send_frame(9'h0C3, 1'b0, 1'b1, NOG);
    chk("R5 irq disabled", rx_irq, 0);
    cfg_irq_en = 1'b1; @(negedge clk);
    chk("R5 irq enabled", rx_irq, 1);
    pop_one();
    chk("R5 irq after pop", rx_irq, 0);
    cfg_irq_en = 1'b0;

    // Enable conditions R2
    cfg_sync_mode = 1'b1;
    send_frame(9'h012, 1'b0, 1'b1, NOG);
    chk("R2 sync mode ignores line", rx_ready, 0);
    cfg_sync_mode = 1'b0; cfg_port_en = 1'b0;
    send_frame(9'h034, 1'b0, 1'b1, NOG);
    chk("R2 port disabled ignores line", rx_ready, 0);
    cfg_port_en = 1'b1;
    repeat (4) @(negedge clk);

    // False start R9
    rx_line = 1'b0; repeat (3 * TICK) @(negedge clk);
    rx_line = 1'b1; repeat (3 * BITCLK) @(negedge clk);
    chk("R9 false start no word", rx_ready, 0);
    send_frame(9'h05A, 1'b0, 1'b1, NOG);
    chk("R9 frame after false start", rd_data, 8'h5A);
    pop_one();

    // Centre glitch R10
    send_frame(9'h0F0, 1'b0, 1'b1, 3);
    chk("R10 glitch on low bit", rd_data, 8'hF0);
    pop_one();
    send_frame(9'h0F0, 1'b0, 1'b1, 5);
    chk("R10 glitch on high bit", rd_data, 8'hF0);
    pop_one();

    // Overrun R7, FIFO order R6, disable R8
    send_frame(9'h011, 1'b0, 1'b1, NOG);
    send_frame(9'h022, 1'b0, 1'b1, NOG);
    chk("R7 no overrun at two words", rd_overrun, 0);
    send_frame(9'h033, 1'b0, 1'b1, NOG);
    chk("R7 overrun on third word", rd_overrun, 1);
    send_frame(9'h044, 1'b0, 1'b1, NOG);
    chk("R7 overrun sticky", rd_overrun, 1);
    cfg_cont_rx = 1'b0;
    @(negedge clk);
    chk("R8 overrun cleared", rd_overrun, 0);
    chk("R8 FIFO kept", rx_ready, 1);
    chk("R6 head is first word", rd_data, 8'h11);
    pop_one();
    chk("R7 second word kept, later dropped", rd_data, 8'h22);
    pop_one();
    chk("R6 empty after two pops", rx_ready, 0);
    pop_one();
    chk("R6 pop on empty ignored", rx_ready, 0);
    cfg_cont_rx = 1'b1;
    repeat (4) @(negedge clk);
    send_frame(9'h066, 1'b0, 1'b1, NOG);
    chk("R8 receive after re-enable", rd_data, 8'h66);
    chk("R6 single word after empty pop", rx_ready, 1);
    pop_one();
    chk("R6 empty again", rx_ready, 0);

    // Simultaneous completion and pop R11: calibrate latency
    reenable();
    t0 = cyc;
    fork
      send_frame(9'h077, 1'b0, 1'b1, NOG);
      begin
        do @(negedge clk); while (!rx_ready);
        lat = cyc - t0;
      end
    join
    pop_one();
    send_frame(9'h0A1, 1'b0, 1'b1, NOG);
    send_frame(9'h0A2, 1'b0, 1'b1, NOG);
    reenable();
    t0 = cyc;
    fork
      send_frame(9'h0A3, 1'b0, 1'b1, NOG);
      begin
        while (cyc != t0 + lat - 1) @(negedge clk);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
      end
    join
    chk("R11 no overrun on pop collision", rd_overrun, 0);
    chk("R11 second word at head", rd_data, 8'hA2);
    pop_one();
    chk("R11 third word stored", rd_data, 8'hA3);
    pop_one();
    chk("R11 empty after reads", rx_ready, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule